// File: doc/BRIEF.md
# SPI Master Serial Engine

This block is the shifting core of a serial peripheral interface master. It takes frames from a transmit queue interface and hands received frames to a receive queue interface. It makes the serial clock from the system clock through a programmable divider and supports all four combinations of clock polarity and phase. The queues and the register file that programs the block sit outside it.

A frame is a parameterised number of bits, from 4 to 32, shifted most significant bit first. The chip-select outputs show the complement of an 8-bit select mask, so several devices can be addressed at once for broadcast. Between back-to-back frames, chip select follows one of three rules. It drops between every frame for the polarity/phase combinations that sample on the leading edge. It stays low for the combinations that sample on the trailing edge, until the transmit queue runs dry. With the hold option set, it stays low until a frame tagged as last has gone out. The output enable follows chip select. A done pulse marks the end of a tagged frame.

Top module: `spi_master_engine`

## Requirements
- R1: The serial clock half period is `clk_div`+1 system cycles. The receive push of a frame comes (2·FRAME_W+1)·(`clk_div`+1) cycles after the cycle in which that frame was popped.
- R2: Transmit data leaves on `mosi` most significant bit first. A device sampling on the capture edge receives exactly the popped word.
- R3: `mode[1]` is the clock idle level and `mode[0]` is the phase. With phase 0, data is captured on the leading edge and changed on the trailing edge. With phase 1, data is changed on the leading edge and captured on the trailing edge. `rx_data` holds the captured bits with the first bit at the most significant position.
- R4: While a packet is active, `ss_n` equals the bitwise complement of `sel_mask`. At all other times it is all ones. Several mask bits may be set at once.
- R5: With `hold_sel` low and `mode[0]`=0, chip select goes inactive after every frame, for at least one half period.
- R6: With `hold_sel` low and `mode[0]`=1, chip select stays active across frames that follow back to back. It goes inactive when the transmit queue is empty at the end of a frame.
- R7: With `hold_sel` high, chip select stays active across frames, including while waiting for data. It goes inactive only after a frame tagged by `tx_last`.
- R8: `oe` is high exactly while chip select is active.
- R9: When `en` is low, `sclk` is 0, `ss_n` is all ones and `oe` is 0 in that same cycle, and the frame in flight is abandoned.
- R10: `tx_pop` is never raised while `tx_empty` is high. The engine waits without producing an underrun.
- R11: `busy` is high while a frame is being shifted. `done` pulses for one cycle together with the receive push of a frame tagged last.
- R12: `rx_push` pulses for one cycle per completed frame, with the full received word on `rx_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Engine enable |
| mode | input | 2 | {clock idle level, clock phase} |
| hold_sel | input | 1 | Keep chip select active until a last-tagged frame |
| clk_div | input | DIV_W | Half-period divider value |
| sel_mask | input | SEL_W | Devices to select, one bit each |
| tx_empty | input | 1 | Transmit queue empty |
| tx_data | input | FRAME_W | Head of transmit queue |
| tx_last | input | 1 | Head frame ends the packet |
| tx_pop | output | 1 | Take the head frame this cycle |
| rx_push | output | 1 | Received frame valid this cycle |
| rx_data | output | FRAME_W | Received frame |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_n | output | SEL_W | Chip selects, active low |
| oe | output | 1 | Data output enable, active high |
| busy | output | 1 | A frame is being shifted |
| done | output | 1 | Last-tagged frame finished |

## Verification
A phase counter that is off by one shows up at once as a wrong distance between pop and push. It also shows a serial clock resting at the wrong level after the frame, and a received word rotated by one bit, so every vector exposes it within one frame. A wrong next-state choice at the end of a frame is caught within one frame time by counting rises of the output enable over a two-frame packet, and by sampling `oe` while the queue is empty. A wrong shift edge corrupts the word that the bench's serial device model captures, and the wrong word is visible at the next push.

// File: rtl/spi_master_engine.sv
module spi_master_engine #(
  parameter int FRAME_W = 8,
  parameter int SEL_W   = 8,
  parameter int DIV_W   = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic [1:0]         mode,
  input  logic               hold_sel,
  input  logic [DIV_W-1:0]   clk_div,
  input  logic [SEL_W-1:0]   sel_mask,
  input  logic               tx_empty,
  input  logic [FRAME_W-1:0] tx_data,
  input  logic               tx_last,
  output logic               tx_pop,
  output logic               rx_push,
  output logic [FRAME_W-1:0] rx_data,
  output logic               sclk,
  output logic               mosi,
  input  logic               miso,
  output logic [SEL_W-1:0]   ss_n,
  output logic               oe,
  output logic               busy,
  output logic               done
);

  localparam int PH_W = $clog2(2*FRAME_W + 1);
  localparam logic [PH_W-1:0] PH_END = PH_W'(2*FRAME_W);

  typedef enum logic [1:0] {S_IDLE, S_XFER, S_WAIT, S_GAP} st_t;

  st_t                st;
  logic [DIV_W-1:0]   cnt;
  logic [PH_W-1:0]    ph;
  logic [FRAME_W-1:0] txsh, rxsh;
  logic               last_q;

  wire cpol      = mode[1];
  wire cpha      = mode[0];
  wire tick      = (cnt == clk_div);
  wire frame_end = (st == S_XFER) && tick && (ph == PH_END);
  wire chain     = frame_end && !tx_empty && !last_q && (hold_sel || cpha);
  wire start     = !tx_empty && (st == S_IDLE || st == S_WAIT);
  wire edge_t    = (st == S_XFER) && tick && (ph != PH_END);
  wire lead      = edge_t && !ph[0];
  wire trail     = edge_t && ph[0];
  wire do_shift  = cpha ? (lead && ph != '0) : trail;
  wire do_samp   = cpha ? trail : lead;
  wire ss_on     = en && (st == S_XFER || st == S_WAIT);

  assign tx_pop  = en && (start || chain);
  assign rx_push = en && frame_end;
  assign done    = rx_push && last_q;
  assign rx_data = rxsh;
  assign busy    = (st == S_XFER);
  assign oe      = ss_on;
  assign ss_n    = ss_on ? ~sel_mask : '1;
  assign sclk    = en && (cpol ^ ((st == S_XFER) && ph[0]));
  assign mosi    = ss_on && txsh[FRAME_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      cnt    <= '0;
      ph     <= '0;
      txsh   <= '0;
      rxsh   <= '0;
      last_q <= 1'b0;
    end else if (!en) begin
      st  <= S_IDLE;
      cnt <= '0;
      ph  <= '0;
    end else begin
      if (tx_pop) begin
        txsh   <= tx_data;
        last_q <= tx_last;
        ph     <= '0;
        cnt    <= '0;
        st     <= S_XFER;
      end else begin
        cnt <= tick ? '0 : cnt + 1'b1;
        case (st)
          S_XFER: if (tick) begin
            if (frame_end) st <= (!last_q && hold_sel) ? S_WAIT : S_GAP;
            else           ph <= ph + 1'b1;
          end
          S_GAP:  if (tick) st <= S_IDLE;
          default: ;
        endcase
        if (do_shift) txsh <= {txsh[FRAME_W-2:0], 1'b0};
      end
      if (do_samp) rxsh <= {rxsh[FRAME_W-2:0], miso};
    end
  end

  a_r10_no_pop_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
    tx_pop |-> !tx_empty);

  a_r11_done_with_push: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (rx_push && busy));

  a_r4_select_matches_mask: assert property (@(posedge clk) disable iff (!rst_n)
    oe |-> (ss_n == ~sel_mask));

  a_r3_clock_rests_at_polarity: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !busy) |-> (sclk == mode[1]));

  a_r1_phase_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    ph <= PH_END);

  a_r7_hold_keeps_select: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en) && hold_sel && $past(hold_sel) && $past(oe) && !$past(done)) |-> oe);

  a_r9_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (!oe && !tx_pop && !rx_push));

endmodule

// File: tb/spi_master_engine_bench.sv
`timescale 1ns/1ps
module spi_master_engine_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic [1:0] mode = 2'd0;
  logic       hold_sel = 1'b0;
  logic [7:0] clk_div = 8'd0;
  logic [7:0] sel_mask = 8'h01;
  logic       tx_pop, rx_push, sclk, mosi, oe, busy, done;
  logic       miso = 1'b0;
  logic [7:0] rx_data, ss_n, tx_data;
  logic       tx_last, tx_empty;

  logic [7:0] q_d [8];
  logic       q_l [8];
  int         qh = 0, qt = 0;
  int         nchk = 0, nfail = 0, rises = 0;
  logic [7:0] s_pat = 8'h00, s_cap = 8'h00;
  int         bi = 0;
  logic       prev_ss = 1'b1;

  assign tx_empty = (qh == qt);
  assign tx_data  = q_d[qh % 8];
  assign tx_last  = q_l[qh % 8];

  always #2 clk = ~clk;

  spi_master_engine u_spi_master_engine (
    .clk(clk), .rst_n(rst_n), .en(en), .mode(mode), .hold_sel(hold_sel),
    .clk_div(clk_div), .sel_mask(sel_mask), .tx_empty(tx_empty), .tx_data(tx_data),
    .tx_last(tx_last), .tx_pop(tx_pop), .rx_push(rx_push), .rx_data(rx_data),
    .sclk(sclk), .mosi(mosi), .miso(miso), .ss_n(ss_n), .oe(oe), .busy(busy), .done(done)
  );

  localparam logic [25:0] VEC [9] = '{
    {2'd0, 8'd0,   8'hA5, 8'h3C},
    {2'd1, 8'd0,   8'h96, 8'hC3},
    {2'd2, 8'd1,   8'h5A, 8'hF0},
    {2'd3, 8'd1,   8'h81, 8'h0F},
    {2'd0, 8'd3,   8'h7E, 8'h81},
    {2'd1, 8'd2,   8'h01, 8'h80},
    {2'd2, 8'd0,   8'hFF, 8'h00},
    {2'd3, 8'd255, 8'h00, 8'hFF},
    {2'd3, 8'd0,   8'hC6, 8'h6C}
  };

  initial forever begin
    @(posedge clk);
    if (tx_pop) qh <= qh + 1;
  end

  initial forever begin
    @(posedge oe);
    rises++;
  end

  initial forever begin
    @(sclk or ss_n[0]);
    if (ss_n[0] !== prev_ss) begin
      prev_ss = ss_n[0];
      if (!ss_n[0]) begin
        bi = 0;
        if (!mode[0]) miso = s_pat[7];
      end
    end else if (!ss_n[0]) begin
      if (sclk != mode[1]) begin
        if (!mode[0]) s_cap = {s_cap[6:0], mosi};
        else          miso = s_pat[7 - (bi % 8)];
      end else begin
        if (!mode[0]) begin
          bi++;
          miso = s_pat[7 - (bi % 8)];
        end else begin
          s_cap = {s_cap[6:0], mosi};
          bi++;
        end
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] d, input logic l);
    q_d[qt % 8] = d;
    q_l[qt % 8] = l;
    qt++;
  endtask

  task automatic wait_for(input int which);
    for (int k = 0; k < 20000; k++) begin
      @(negedge clk);
      if ((which == 0 && rx_push) || (which == 1 && done)) return;
    end
    chk("R12 frame completion timeout", 0, 1);
  endtask

  task automatic run_vec(input logic [25:0] v);
    int t1;
    logic [7:0] got;
    logic dn;
    t1 = -1; got = '0; dn = 1'b0;
    mode = v[25:24]; clk_div = v[23:16]; s_pat = v[7:0];
    @(negedge clk);
    push(v[15:8], 1'b1);
    #0.5;
    chk("R10 pop when data present", tx_pop, 1);
    for (int k = 1; k < 20000 && t1 < 0; k++) begin
      @(negedge clk);
      if (rx_push) begin t1 = k; got = rx_data; dn = done; end
    end
    chk("R1 pop to push distance", t1, 17 * (int'(v[23:16]) + 1));
    chk("R3 R12 received word", got, v[7:0]);
    chk("R11 done with last frame", dn, 1);
    repeat (int'(v[23:16]) + 3) @(negedge clk);
    chk("R2 device captured word", s_cap, v[15:8]);
    chk("R3 clock idle level", sclk, v[25]);
    chk("R8 output enable released", oe, 0);
  endtask

  initial begin
    #600000;
    nfail++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    bit popped;
    repeat (3) @(negedge clk);
    chk("R4 reset selects idle", ss_n, 8'hFF);
    chk("R8 reset oe low", oe, 0);
    chk("R9 reset sclk low", sclk, 0);
    chk("R11 reset not busy", busy, 0);
    rst_n = 1'b1;
    en = 1'b1;
    @(negedge clk);

    foreach (VEC[i]) run_vec(VEC[i]);

    // R4 broadcast
    mode = 2'd0; clk_div = 8'd1; sel_mask = 8'h21;
    @(negedge clk); push(8'h3A, 1'b1);
    repeat (4) @(negedge clk);
    chk("R4 broadcast select", ss_n, 8'hDE);
    wait_for(1); repeat (5) @(negedge clk);
    chk("R4 select released", ss_n, 8'hFF);
    sel_mask = 8'h01;

    // R5 pulse between frames
    mode = 2'd0; clk_div = 8'd0; hold_sel = 1'b0; rises = 0;
    @(negedge clk); push(8'h11, 1'b0); push(8'h22, 1'b1);
    wait_for(1); repeat (4) @(negedge clk);
    chk("R5 select pulses per frame", rises, 2);

    // R6 held across back-to-back frames
    mode = 2'd1; rises = 0;
    @(negedge clk); push(8'h33, 1'b0); push(8'h44, 1'b1);
    wait_for(1); repeat (4) @(negedge clk);
    chk("R6 select held back to back", rises, 1);

    // R6 released when queue runs dry
    rises = 0;
    @(negedge clk); push(8'h55, 1'b0);
    wait_for(0); repeat (4) @(negedge clk);
    chk("R6 select released on empty", oe, 0);
    push(8'h66, 1'b1);
    wait_for(1); repeat (4) @(negedge clk);
    chk("R6 two selections", rises, 2);

    // R7 hold option
    mode = 2'd0; hold_sel = 1'b1; rises = 0;
    @(negedge clk); push(8'h77, 1'b0); push(8'h88, 1'b1);
    wait_for(1); repeat (4) @(negedge clk);
    chk("R7 held in leading-phase mode", rises, 1);
    rises = 0;
    push(8'h99, 1'b0);
    wait_for(0); repeat (10) @(negedge clk);
    chk("R7 held while waiting", oe, 1);
    chk("R11 not busy while waiting", busy, 0);
    push(8'hAA, 1'b1);
    wait_for(1); repeat (4) @(negedge clk);
    chk("R7 released after last", oe, 0);
    chk("R7 single selection", rises, 1);
    hold_sel = 1'b0;

    // R9 disable mid-frame
    mode = 2'd2; clk_div = 8'd3;
    @(negedge clk); push(8'hBB, 1'b1);
    repeat (10) @(negedge clk);
    chk("R11 busy mid-frame", busy, 1);
    en = 1'b0;
    #0.5;
    chk("R9 sclk low when disabled", sclk, 0);
    chk("R9 selects idle when disabled", ss_n, 8'hFF);
    chk("R9 oe low when disabled", oe, 0);
    @(negedge clk);
    chk("R9 frame abandoned", busy, 0);

    // R10 idle on empty queue
    en = 1'b1; popped = 1'b0;
    repeat (20) begin @(negedge clk); if (tx_pop) popped = 1'b1; end
    chk("R10 no pop when empty", popped, 0);
    chk("R3 idle level after enable", sclk, 1);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

endmodule